// File: doc/BRIEF.md
# Start-Pin Sequenced Serial ADC Reader

This block lets a host fetch 12-bit samples from a successive-approximation converter. The converter has one conversion-start pin and a three-wire read-out port. It has no command word. The block picks the converter's input, either channel one versus channel two or unipolar versus bipolar, by the shape of the start pulse alone.

A request with `sel_i` low raises the start pin once. A request with `sel_i` high gives a short high pulse, a short low gap, and then the final rise. After the final rise, the start pin stays high for the acquisition window. It then falls, which begins the conversion. The block waits out the conversion time and then runs a mode-0 serial clock: the clock idles low and data is taken on rising edges. It shifts the result in MSB first.

When the word is complete, the block raises `valid_o` for one cycle and presents the result widened to 16 bits. The result is sign-extended when bipolar mode was requested and zero-extended otherwise. `busy_o` covers the whole transaction, and requests that arrive during it are ignored.

The state machine has nine states:

- `ST_IDLE`: start pin low; on a request it goes to `ST_PRE_HI` when `sel_i`=1, or to `ST_ACQ` when `sel_i`=0.
- `ST_PRE_HI`: the short high pulse; goes to `ST_PRE_LO` when the pulse timer expires.
- `ST_PRE_LO`: the short low gap; goes to `ST_ACQ` when the gap timer expires.
- `ST_ACQ`: the start pin is held high; goes to `ST_CONV` when the acquisition timer expires.
- `ST_CONV`: the start pin is low while the converter works; goes to `ST_SCK_HI` when the conversion timer expires, and this transition takes the first bit.
- `ST_SCK_HI`: the serial clock is high. When its timer expires it goes to one of three states:
  - `ST_DONE` after the last rise;
  - `ST_GAP` after the eighth rise in two-byte mode;
  - `ST_SCK_LO` otherwise.
- `ST_SCK_LO`: the serial clock is low; goes to `ST_SCK_HI` when its timer expires, and this transition takes the next bit.
- `ST_GAP`: the pause between the two bytes; goes to `ST_SCK_LO`.
- `ST_DONE`: the one-cycle strobe; goes to `ST_IDLE`.

Top module: `adc_seq_host`

## Requirements
- R1: After reset, and whenever no request is in progress, `cnvst_o`, `sclk_o`, `busy_o` and `valid_o` are low. After reset, `data_o` is zero.
- R2: A request with `sel_i`=0 produces exactly one rise of `cnvst_o`. The pin then stays high for exactly ACQ_CYC cycles.
- R3: A request with `sel_i`=1 produces two rises of `cnvst_o` in this pattern: high for PULSE_CYC cycles, low for PULSE_CYC cycles, then high for ACQ_CYC cycles.
- R4: From the fall of `cnvst_o` to the first rise of `sclk_o`, exactly CONV_CYC cycles pass with both lines low.
- R5: Every high phase of `sclk_o` lasts HALF_CYC cycles. Every low phase between two rises lasts HALF_CYC cycles, except the byte gap of R7. `sclk_o` is never high while `cnvst_o` is high.
- R6: In single-word mode, `sclk_o` rises 12 times. `sdo_i` is sampled at each rise, and the first sample is result bit 11 (MSB first).
- R7: In two-byte mode, `sclk_o` rises 16 times. The low phase after the eighth rise lasts GAP_CYC+HALF_CYC cycles. The values sampled on rises 13 to 16 do not affect the result.
- R8: With DIFF_INPUT=1 and `sel_i`=1, `data_o[15:12]` copy result bit 11 (two's complement). In every other case, `data_o[15:12]` are zero. `data_o[11:0]` always hold the 12-bit result.
- R9: `busy_o` goes high in the cycle after a request is accepted and stays high through the `valid_o` cycle. `valid_o` lasts one cycle, and both outputs are low in the cycle after it.
- R10: A request, or a change of `sel_i`, while `busy_o` is high has no effect. It changes neither the pulse pattern nor the result, and no second transaction follows.
- R11: Each wait is computed as ceil(max(ns, minimum)/CLK_NS) cycles. The minimums are 1400 ns for acquisition, 3700 ns for conversion, 30 ns for the select pulse and gap, and 63 ns for a clock half-period. The 63 ns minimum keeps the clock at or below 8 MHz and each phase at or above 38 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, taken when idle |
| sel_i | input | 1 | 0: first channel or unipolar; 1: second channel or bipolar |
| sdo_i | input | 1 | Serial data from the converter |
| cnvst_o | output | 1 | Conversion start pin to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle strobe marking `data_o` as new |
| data_o | output | OUT_W | Extended result |

## Verification
The embedded assertions check the following on every cycle:

- the idle lines stay quiet;
- the serial clock never overlaps the start pulse;
- the strobe lies inside busy and is followed by idle;
- the latched select cannot change mid-transaction;
- every clock high phase has the programmed length.

Some behaviours only the bench scenarios can show: the exact start-pulse lengths for each select, the conversion gap, the byte gap, the number of clock rises and the assembled, extended result. The bench shows these by sweeping result codes and both selects over two configurations, one of which uses non-integral timing values that force rounding up.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_ACQ,
        ST_CONV,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    // ceil(max(ns, floor_ns) / clk_ns), never below one cycle
    function automatic int ns_to_cyc(input int ns, input int floor_ns, input int clk_ns);
        int eff;
        int c;
        eff = (ns < floor_ns) ? floor_ns : ns;
        c = (eff + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          done_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/adc_seq_shift.sv
`timescale 1ns/1ps
module adc_seq_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         take_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (clr_i) begin
            word_o <= '0;
        end else if (take_i) begin
            word_o <= {word_o[W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/adc_seq_host.sv
`timescale 1ns/1ps
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int ACQ_NS      = 1400,
    parameter int CONV_NS     = 3700,
    parameter int PULSE_NS    = 30,
    parameter int SCK_HALF_NS = 63,
    parameter int GAP_NS      = 200,
    parameter int RES_W       = 12,
    parameter int OUT_W       = 16,
    parameter bit TWO_BYTE    = 1'b0,
    parameter bit DIFF_INPUT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             sel_i,
    input  logic             sdo_i,
    output logic             cnvst_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] data_o
);
    localparam int ACQ_CYC   = ns_to_cyc(ACQ_NS, 1400, CLK_NS);
    localparam int CONV_CYC  = ns_to_cyc(CONV_NS, 3700, CLK_NS);
    localparam int PULSE_CYC = ns_to_cyc(PULSE_NS, 30, CLK_NS);
    localparam int HALF_CYC  = ns_to_cyc(SCK_HALF_NS, 63, CLK_NS);
    localparam int GAP_CYC   = ns_to_cyc(GAP_NS, 1, CLK_NS);
    localparam int M1   = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
    localparam int M2   = (PULSE_CYC > HALF_CYC) ? PULSE_CYC : HALF_CYC;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > GAP_CYC) ? M3 : GAP_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int XFER_BITS = TWO_BYTE ? 16 : RES_W;
    localparam int CW   = $clog2(XFER_BITS + 1);

    seq_state_e     st_q, st_d;
    logic           tload, tdone, sample;
    logic [TW-1:0]  tval;
    logic           sel_q, signed_mode;
    logic [CW-1:0]  bitcnt_q;
    logic [RES_W-1:0] word;
    logic [OUT_W-1:0] data_q;
    logic [TW-1:0]  hi_len;

    adc_seq_timer #(.TW(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(tload), .val_i(tval), .done_o(tdone)
    );

    adc_seq_shift #(.W(RES_W)) shf_i (
        .clk(clk), .rst_n(rst_n),
        .clr_i(st_q == ST_IDLE && req_i),
        .take_i(sample && (bitcnt_q < CW'(RES_W))),
        .bit_i(sdo_i), .word_o(word)
    );

    generate
        if (DIFF_INPUT) begin : g_diff
            assign signed_mode = sel_q;
        end else begin : g_single
            assign signed_mode = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        tload  = 1'b0;
        tval   = '0;
        sample = 1'b0;
        unique case (st_q)
            ST_IDLE: if (req_i) begin
                tload = 1'b1;
                if (sel_i) begin
                    st_d = ST_PRE_HI;
                    tval = TW'(PULSE_CYC - 1);
                end else begin
                    st_d = ST_ACQ;
                    tval = TW'(ACQ_CYC - 1);
                end
            end
            ST_PRE_HI: if (tdone) begin
                st_d = ST_PRE_LO; tload = 1'b1; tval = TW'(PULSE_CYC - 1);
            end
            ST_PRE_LO: if (tdone) begin
                st_d = ST_ACQ; tload = 1'b1; tval = TW'(ACQ_CYC - 1);
            end
            ST_ACQ: if (tdone) begin
                st_d = ST_CONV; tload = 1'b1; tval = TW'(CONV_CYC - 1);
            end
            ST_CONV: if (tdone) begin
                st_d = ST_SCK_HI; tload = 1'b1; tval = TW'(HALF_CYC - 1); sample = 1'b1;
            end
            ST_SCK_HI: if (tdone) begin
                if (bitcnt_q == CW'(XFER_BITS)) begin
                    st_d = ST_DONE;
                end else if (TWO_BYTE && bitcnt_q == CW'(8)) begin
                    st_d = ST_GAP; tload = 1'b1; tval = TW'(GAP_CYC - 1);
                end else begin
                    st_d = ST_SCK_LO; tload = 1'b1; tval = TW'(HALF_CYC - 1);
                end
            end
            ST_SCK_LO: if (tdone) begin
                st_d = ST_SCK_HI; tload = 1'b1; tval = TW'(HALF_CYC - 1); sample = 1'b1;
            end
            ST_GAP: if (tdone) begin
                st_d = ST_SCK_LO; tload = 1'b1; tval = TW'(HALF_CYC - 1);
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            sel_q    <= 1'b0;
            bitcnt_q <= '0;
            data_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE) begin
                bitcnt_q <= '0;
                if (req_i) sel_q <= sel_i;
            end else if (sample) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (st_q == ST_SCK_HI && st_d == ST_DONE) begin
                data_q <= signed_mode ? {{(OUT_W-RES_W){word[RES_W-1]}}, word}
                                      : {{(OUT_W-RES_W){1'b0}}, word};
            end
        end
    end

    always_comb begin
        cnvst_o = (st_q == ST_PRE_HI) || (st_q == ST_ACQ);
        sclk_o  = (st_q == ST_SCK_HI);
        busy_o  = (st_q != ST_IDLE);
        valid_o = (st_q == ST_DONE);
        data_o  = data_q;
    end

    // high-phase length monitor for the clock-width check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_len <= '0;
        else if (sclk_o) hi_len <= hi_len + 1'b1;
        else             hi_len <= '0;
    end

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cnvst_o && !sclk_o && !valid_o)); // R1
    AST_NO_SCLK_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> !sclk_o); // R5
    AST_SCLK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_len == TW'(HALF_CYC))); // R5
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o); // R9
    AST_VALID_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (!valid_o && !busy_o)); // R9
    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !valid_o) |=> $stable(sel_q)); // R10

endmodule

// File: tb/adc_seq_host_tb_top.sv
`timescale 1ns/1ps
package adc_seq_tb_pkg;
    typedef struct packed {
        int n_crise;
        int first_hi;
        int last_hi;
        int mid_lo;
        int conv_gap;
        int n_sclk;
        int min_hi;
        int max_hi;
        int min_lo;
        int max_lo;
        int overlap;
    } mon_t;
endpackage

module adc_seq_resp_mon
    import adc_seq_tb_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        cnvst,
    input  logic        sclk,
    input  logic [11:0] word,
    output logic        dout,
    output mon_t        st
);
    int idx = -1;
    logic prev_c = 1'b0, prev_s = 1'b0;
    int run_c = 0, run_s = 0, since_fall = 0;
    bit seen_fall = 0;

    initial dout = 1'b0;

    always @(negedge cnvst) begin
        idx = 11;
        dout = word[11];
    end
    always @(negedge sclk) begin
        if (idx > 0) begin
            idx = idx - 1;
            dout = word[idx];
        end else begin
            idx = -1;
            dout = 1'b1;   // trailing bits are ones and must be ignored
        end
    end

    always @(negedge clk) begin
        if (clr) begin
            st = '{default: 0};
            st.min_hi = 99999;
            st.min_lo = 99999;
            seen_fall = 0;
            since_fall = 0;
        end else begin
            if (cnvst != prev_c) begin
                if (prev_c) begin
                    if (st.n_crise == 1) st.first_hi = run_c;
                    st.last_hi = run_c;
                    seen_fall = 1;
                    since_fall = 1;
                end else begin
                    if (st.n_crise > 0) st.mid_lo = run_c;
                    st.n_crise++;
                end
                run_c = 1;
            end else begin
                run_c++;
                if (seen_fall && st.n_sclk == 0 && !sclk && !cnvst) since_fall++;
            end
            if (sclk != prev_s) begin
                if (prev_s) begin
                    if (run_s < st.min_hi) st.min_hi = run_s;
                    if (run_s > st.max_hi) st.max_hi = run_s;
                end else begin
                    st.n_sclk++;
                    if (st.n_sclk == 1) st.conv_gap = since_fall;
                    else begin
                        if (run_s < st.min_lo) st.min_lo = run_s;
                        if (run_s > st.max_lo) st.max_lo = run_s;
                    end
                end
                run_s = 1;
            end else begin
                run_s++;
            end
            if (cnvst && sclk) st.overlap = 1;
        end
        prev_c = cnvst;
        prev_s = sclk;
    end
endmodule

module adc_seq_host_tb_top;
    import adc_seq_tb_pkg::*;

    localparam int B_ACQ_NS = 1401;
    localparam int B_HALF_NS = 75;
    localparam int B_GAP_NS = 95;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic req_x = 1'b0, sel_x = 1'b0, clr = 1'b0, cur = 1'b0;
    logic [11:0] word_x = '0;
    logic req_a, req_b;
    logic sdo_a, sdo_b, cnv_a, cnv_b, sck_a, sck_b;
    logic busy_a, busy_b, val_a, val_b;
    logic [15:0] dat_a, dat_b;
    mon_t st_a, st_b, cs;
    logic c_busy, c_valid, c_cnv, c_sck;
    logic [15:0] c_dat;

    int checks = 0;
    int errors = 0;

    assign req_a = req_x && !cur;
    assign req_b = req_x && cur;
    assign cs = cur ? st_b : st_a;
    assign c_busy = cur ? busy_b : busy_a;
    assign c_valid = cur ? val_b : val_a;
    assign c_cnv = cur ? cnv_b : cnv_a;
    assign c_sck = cur ? sck_b : sck_a;
    assign c_dat = cur ? dat_b : dat_a;

    adc_seq_host #(.CLK_NS(10), .ACQ_NS(1400), .CONV_NS(3700), .PULSE_NS(30),
                   .SCK_HALF_NS(63), .GAP_NS(200), .TWO_BYTE(1'b0), .DIFF_INPUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_a), .sel_i(sel_x), .sdo_i(sdo_a),
        .cnvst_o(cnv_a), .sclk_o(sck_a), .busy_o(busy_a), .valid_o(val_a), .data_o(dat_a));

    adc_seq_host #(.CLK_NS(10), .ACQ_NS(B_ACQ_NS), .CONV_NS(3700), .PULSE_NS(30),
                   .SCK_HALF_NS(B_HALF_NS), .GAP_NS(B_GAP_NS), .TWO_BYTE(1'b1), .DIFF_INPUT(1'b0)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_b), .sel_i(sel_x), .sdo_i(sdo_b),
        .cnvst_o(cnv_b), .sclk_o(sck_b), .busy_o(busy_b), .valid_o(val_b), .data_o(dat_b));

    adc_seq_resp_mon mon_a (.clk(clk), .clr(clr), .cnvst(cnv_a), .sclk(sck_a),
                            .word(word_x), .dout(sdo_a), .st(st_a));
    adc_seq_resp_mon mon_b (.clk(clk), .clr(clr), .cnvst(cnv_b), .sclk(sck_b),
                            .word(word_x), .dout(sdo_b), .st(st_b));

    function automatic int cyc(input int ns, input int lo);
        int e;
        e = (ns < lo) ? lo : ns;
        return (e + 9) / 10;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_conv(input bit b, input bit sel, input logic [11:0] w, input bit spam);
        int e_acq, e_pulse, e_conv, e_half, e_gap, e_bits;
        bit e_sign, got;
        logic [15:0] e_dat;
        e_acq   = b ? cyc(B_ACQ_NS, 1400) : cyc(1400, 1400);
        e_pulse = cyc(30, 30);
        e_conv  = cyc(3700, 3700);
        e_half  = b ? cyc(B_HALF_NS, 63) : cyc(63, 63);
        e_gap   = b ? cyc(B_GAP_NS, 1) : 0;
        e_bits  = b ? 16 : 12;
        e_sign  = !b && sel;
        e_dat   = e_sign ? {{4{w[11]}}, w} : {4'b0000, w};
        @(negedge clk);
        cur = b; word_x = w; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; req_x = 1'b1; sel_x = sel;
        @(negedge clk);
        req_x = 1'b0;
        chk("R9 busy after accept", c_busy, 1);
        got = 0;
        for (int n = 0; n < 5000; n++) begin
            if (spam && n < 100) begin
                req_x = (n % 5 == 0);
                sel_x = ~sel;
            end else begin
                req_x = 1'b0;
            end
            @(negedge clk);
            if (c_valid) begin got = 1; break; end
            if (!c_busy) begin
                chk("R9 busy dropped before valid", 0, 1);
                break;
            end
        end
        req_x = 1'b0;
        chk("R9 valid reached", got, 1);
        chk("R8 result value", c_dat, e_dat);
        @(negedge clk);
        chk("R9 busy low after valid", c_busy, 0);
        chk("R9 valid one cycle", c_valid, 0);
        @(negedge clk);
        chk("R10 no restart after ignored requests", c_busy | c_cnv, 0);
        if (sel) begin
            chk("R3 rises", cs.n_crise, 2);
            chk("R3 first pulse", cs.first_hi, e_pulse);
            chk("R3 low gap", cs.mid_lo, e_pulse);
            chk("R3 acquisition", cs.last_hi, e_acq);
        end else begin
            chk("R2 rises", cs.n_crise, 1);
            chk("R2 acquisition", cs.last_hi, e_acq);
        end
        chk("R4 conversion wait", cs.conv_gap, e_conv);
        chk(b ? "R7 clock rises" : "R6 clock rises", cs.n_sclk, e_bits);
        chk("R5 high min", cs.min_hi, e_half);
        chk("R5 high max", cs.max_hi, e_half);
        chk("R5 low min", cs.min_lo, e_half);
        chk(b ? "R7 byte gap" : "R5 low max", cs.max_lo, e_half + e_gap);
        chk("R5 no overlap", cs.overlap, 0);
    endtask

    initial begin
        #1900000;
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #23;
        chk("R1 reset cnvst", cnv_a | cnv_b, 0);
        chk("R1 reset sclk", sck_a | sck_b, 0);
        chk("R1 reset busy/valid", busy_a | busy_b | val_a | val_b, 0);
        chk("R1 reset data", int'(dat_a | dat_b), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle lines", cnv_a | sck_a | busy_a, 0);
        chk("R11 rounding acq", cyc(B_ACQ_NS, 1400), 141);
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 2; s++) begin
                for (int w = 0; w < 4096; w += 273)
                    run_conv(b[0], s[0], w[11:0], (w % 3) == 0);
                run_conv(b[0], s[0], 12'h000, 1'b0);
                run_conv(b[0], s[0], 12'h7FF, 1'b1);
                run_conv(b[0], s[0], 12'h800, 1'b0);
                run_conv(b[0], s[0], 12'hFFF, 1'b1);
                run_conv(b[0], s[0], 12'h001, 1'b0);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule